// File: doc/BRIEF.md
# Card Sector Read Sequencer

This block is a bus master that reads a run of 512-byte sectors out of a memory-card controller. It works through a small 16-bit register window. A start pulse latches a 24-bit starting block address and an 8-bit sector count. The sequencer then claims the controller's lock and waits until the card reports that it will take a command. It programs the address, the count and the read command, and starts the transfer. After that it empties the controller's data buffer in chunks and sends every data word downstream as two bytes on a valid/ready stream.

Each exit path gives the lock back with a final control write. After that write the block pulses `done_o` together with an error code and the number of sectors delivered. That number is zero on any failure. Waits between polls are counted in ticks of a prescaler, so the same logic runs with millisecond spacing in silicon and with a few clocks in simulation. Bus transfers use a request/acknowledge handshake with one transaction outstanding at a time.

Top module: `card_sector_reader`

## Requirements
- R1: The first bus transaction after an accepted start is a write of 0x0002 to control (byte offset 0x18). Status (offset 0x04) is then read until bit 1 is set. At most LOCK_TRIES reads are made, and at least LOCK_GAP prescaler ticks separate two of them. If every read shows bit 1 clear, the run fails with code 2 when status bit 4 was set in the last read, and with code 1 otherwise.
- R2: While the block waits for command readiness, a status read with bit 4 (card present) clear ends the run with code 1 (card missing).
- R3: Once the lock is held, status is read until bit 8 (ready for command) is set. At most RDY_TRIES reads are made, spaced by RDY_GAP ticks. If they all run out, the run fails with code 3.
- R4: On readiness, four writes follow in this order: lba[15:0] to 0x10, {8'h00, lba[23:16]} to 0x12, {8'h03, count} to 0x14, and 0x0082 to 0x18.
- R5: For each of count×CHUNKS_PER_SECTOR chunks, status is polled until bit 5 (buffer ready) is set, spaced by BUF_GAP ticks. Then WORDS_PER_CHUNK reads of offset 0x40 are made.
- R6: Each data word leaves as two stream bytes, bits [7:0] first and then bits [15:8]. A byte on `byte_data_o` stays stable with `byte_valid_o` high until `byte_ready_i` takes it.
- R7: A read of offset 0x40 is requested only while no byte of the previous word is waiting on the stream.
- R8: Every run ends with a write of 0x0000 to 0x18, then a one-cycle `done_o`. Every data byte has been taken before that pulse. `err_code_o` is 0 on success. `sectors_o` equals the count on success and 0 on failure.
- R9: Once `bus_req_o` is raised, it stays high and `bus_we_o`, `bus_addr_o` and `bus_wdata_o` stay stable until the cycle in which `bus_ack_i` is sampled high. No request is made while the block is idle.
- R10: A start pulse that arrives while `busy_o` is high is ignored. No extra run, write or done pulse results from it.
- R11: A count of zero runs the lock, readiness and programming steps, with command word 0x0300. It reads no data and finishes with code 0 and zero sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| lba_i | input | 24 | First block address |
| count_i | input | 8 | Number of sectors to read |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_code_o | output | 2 | 0 ok, 1 card missing, 2 lock not granted, 3 not ready |
| sectors_o | output | 8 | Sectors delivered by the last run |
| bus_req_o | output | 1 | Register transaction request |
| bus_we_o | output | 1 | Transaction is a write |
| bus_addr_o | output | 7 | Register byte offset |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Transaction complete; read data valid |
| bus_rdata_i | input | 16 | Read data |
| byte_valid_o | output | 1 | Stream byte valid |
| byte_data_o | output | 8 | Stream byte |
| byte_ready_i | input | 1 | Downstream accepts the byte |

## Verification
The hardest cases to reach are the ones where a retry window runs out exactly, and the one where the card disappears after the lock has been granted. Both depend on what the controller returns on a given poll. The bench therefore models the controller itself. Each run is set up with the poll number on which the lock is granted, the poll number on which readiness appears, and whether the presence bit drops once the lock is held. This lets it place a grant on the last allowed try, one try beyond it, or never. A slow, stalling downstream ready is also used, to hold the block at the gate before each data read.

// File: rtl/csr_pkg.sv
package csr_pkg;
    localparam int BUS_AW = 7;
    localparam int BUS_DW = 16;
    localparam int LBA_W  = 24;
    localparam int CNT_W  = 8;

    localparam logic [BUS_AW-1:0] OFS_STATUS = 7'h04;
    localparam logic [BUS_AW-1:0] OFS_LBA_LO = 7'h10;
    localparam logic [BUS_AW-1:0] OFS_LBA_HI = 7'h12;
    localparam logic [BUS_AW-1:0] OFS_CMD    = 7'h14;
    localparam logic [BUS_AW-1:0] OFS_CTRL   = 7'h18;
    localparam logic [BUS_AW-1:0] OFS_DATA   = 7'h40;

    localparam int BIT_LOCKED = 1;
    localparam int BIT_CARD   = 4;
    localparam int BIT_BUFRDY = 5;
    localparam int BIT_CMDRDY = 8;

    localparam logic [BUS_DW-1:0] CTRL_TAKE = 16'h0002;
    localparam logic [BUS_DW-1:0] CTRL_RUN  = 16'h0082;
    localparam logic [BUS_DW-1:0] CTRL_FREE = 16'h0000;
    localparam logic [7:0]        CMD_READ_HI = 8'h03;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_NO_CARD   = 2'd1,
        ERR_LOCK      = 2'd2,
        ERR_NOT_READY = 2'd3
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_LOCK_WR, S_LOCK_RD, S_LOCK_WAIT,
        S_RDY_RD, S_RDY_WAIT, S_LBA_LO, S_LBA_HI,
        S_CMD, S_GO, S_BUF_RD, S_BUF_WAIT,
        S_DATA_GATE, S_DATA_RD, S_DRAIN, S_RELEASE
    } st_e;
endpackage

// File: rtl/csr_tick_gen.sv
module csr_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == W'(DIV - 1));
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/csr_byte_pair.sv
module csr_byte_pair (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [15:0] word_i,
    output logic        valid_o,
    output logic [7:0]  data_o,
    input  logic        ready_i,
    output logic        empty_o
);
    typedef struct packed {
        logic [15:0] word;
        logic        hi;
        logic        valid;
    } pair_t;

    pair_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (p_q.valid && ready_i) begin
            if (p_q.hi) p_d.valid = 1'b0;
            else        p_d.hi    = 1'b1;
        end
        if (load_i) begin
            p_d.word  = word_i;
            p_d.hi    = 1'b0;
            p_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign valid_o = p_q.valid;
    assign data_o  = p_q.hi ? p_q.word[15:8] : p_q.word[7:0];
    assign empty_o = !p_q.valid;
endmodule

// File: rtl/card_sector_reader.sv
module card_sector_reader
    import csr_pkg::*;
#(
    parameter int TICK_DIV          = 100000,
    parameter int LOCK_TRIES        = 11,
    parameter int LOCK_GAP          = 100,
    parameter int RDY_TRIES         = 2001,
    parameter int RDY_GAP           = 1,
    parameter int BUF_GAP           = 1,
    parameter int WORDS_PER_CHUNK   = 16,
    parameter int CHUNKS_PER_SECTOR = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [23:0] lba_i,
    input  logic [7:0]  count_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [1:0]  err_code_o,
    output logic [7:0]  sectors_o,
    output logic        bus_req_o,
    output logic        bus_we_o,
    output logic [6:0]  bus_addr_o,
    output logic [15:0] bus_wdata_o,
    input  logic        bus_ack_i,
    input  logic [15:0] bus_rdata_i,
    output logic        byte_valid_o,
    output logic [7:0]  byte_data_o,
    input  logic        byte_ready_i
);
    localparam int MAX_TRIES = (LOCK_TRIES > RDY_TRIES) ? LOCK_TRIES : RDY_TRIES;
    localparam int MAX_GAP_A = (LOCK_GAP > RDY_GAP) ? LOCK_GAP : RDY_GAP;
    localparam int MAX_GAP   = (MAX_GAP_A > BUF_GAP) ? MAX_GAP_A : BUF_GAP;
    localparam int TRY_W     = $clog2(MAX_TRIES + 1);
    localparam int GAP_W     = $clog2(MAX_GAP + 1);
    localparam int WORD_W    = (WORDS_PER_CHUNK > 1) ? $clog2(WORDS_PER_CHUNK) : 1;
    localparam int CH_W      = CNT_W + $clog2(CHUNKS_PER_SECTOR + 1);

    typedef struct packed {
        st_e                st;
        logic               req;
        logic               we;
        logic [BUS_AW-1:0]  addr;
        logic [BUS_DW-1:0]  wdata;
        logic [TRY_W-1:0]   tries;
        logic [GAP_W-1:0]   gap;
        logic [CH_W-1:0]    chunk;
        logic [WORD_W-1:0]  word;
        logic [LBA_W-1:0]   lba;
        logic [CNT_W-1:0]   cnt;
        err_e               err;
        logic               done;
        logic [CNT_W-1:0]   sectors;
    } ctl_t;

    ctl_t r_d, r_q;
    logic tick;
    logic acked;
    logic load;
    logic pair_empty;
    logic [CH_W-1:0] last_chunk;

    function automatic ctl_t go_bus(ctl_t s, st_e nxt, logic we,
                                    logic [BUS_AW-1:0] a, logic [BUS_DW-1:0] d);
        ctl_t t;
        t       = s;
        t.st    = nxt;
        t.req   = 1'b1;
        t.we    = we;
        t.addr  = a;
        t.wdata = d;
        return t;
    endfunction

    function automatic ctl_t park(ctl_t s, st_e nxt);
        ctl_t t;
        t     = s;
        t.st  = nxt;
        t.req = 1'b0;
        t.gap = '0;
        return t;
    endfunction

    csr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    csr_byte_pair u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (bus_rdata_i),
        .valid_o (byte_valid_o),
        .data_o  (byte_data_o),
        .ready_i (byte_ready_i),
        .empty_o (pair_empty)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        load       = 1'b0;
        acked      = r_q.req && bus_ack_i;
        last_chunk = CH_W'(r_q.cnt) * CH_W'(CHUNKS_PER_SECTOR) - 1'b1;
        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.lba   = lba_i;
                    r_d.cnt   = count_i;
                    r_d.err   = ERR_NONE;
                    r_d.tries = '0;
                    r_d       = go_bus(r_d, S_LOCK_WR, 1'b1, OFS_CTRL, CTRL_TAKE);
                end
            end
            S_LOCK_WR: begin
                if (acked) r_d = go_bus(r_q, S_LOCK_RD, 1'b0, OFS_STATUS, '0);
            end
            S_LOCK_RD: begin
                if (acked) begin
                    if (bus_rdata_i[BIT_LOCKED]) begin
                        r_d.tries = '0;
                        r_d       = go_bus(r_d, S_RDY_RD, 1'b0, OFS_STATUS, '0);
                    end else if (r_q.tries == TRY_W'(LOCK_TRIES - 1)) begin
                        r_d.err = bus_rdata_i[BIT_CARD] ? ERR_LOCK : ERR_NO_CARD;
                        r_d     = go_bus(r_d, S_RELEASE, 1'b1, OFS_CTRL, CTRL_FREE);
                    end else begin
                        r_d.tries = r_q.tries + 1'b1;
                        r_d       = park(r_d, S_LOCK_WAIT);
                    end
                end
            end
            S_LOCK_WAIT: begin
                if (tick) begin
                    if (r_q.gap == GAP_W'(LOCK_GAP - 1))
                        r_d = go_bus(r_q, S_LOCK_RD, 1'b0, OFS_STATUS, '0);
                    else
                        r_d.gap = r_q.gap + 1'b1;
                end
            end
            S_RDY_RD: begin
                if (acked) begin
                    if (!bus_rdata_i[BIT_CARD]) begin
                        r_d.err = ERR_NO_CARD;
                        r_d     = go_bus(r_d, S_RELEASE, 1'b1, OFS_CTRL, CTRL_FREE);
                    end else if (bus_rdata_i[BIT_CMDRDY]) begin
                        r_d = go_bus(r_q, S_LBA_LO, 1'b1, OFS_LBA_LO, r_q.lba[15:0]);
                    end else if (r_q.tries == TRY_W'(RDY_TRIES - 1)) begin
                        r_d.err = ERR_NOT_READY;
                        r_d     = go_bus(r_d, S_RELEASE, 1'b1, OFS_CTRL, CTRL_FREE);
                    end else begin
                        r_d.tries = r_q.tries + 1'b1;
                        r_d       = park(r_d, S_RDY_WAIT);
                    end
                end
            end
            S_RDY_WAIT: begin
                if (tick) begin
                    if (r_q.gap == GAP_W'(RDY_GAP - 1))
                        r_d = go_bus(r_q, S_RDY_RD, 1'b0, OFS_STATUS, '0);
                    else
                        r_d.gap = r_q.gap + 1'b1;
                end
            end
            S_LBA_LO: begin
                if (acked)
                    r_d = go_bus(r_q, S_LBA_HI, 1'b1, OFS_LBA_HI, {8'h00, r_q.lba[23:16]});
            end
            S_LBA_HI: begin
                if (acked)
                    r_d = go_bus(r_q, S_CMD, 1'b1, OFS_CMD, {CMD_READ_HI, r_q.cnt});
            end
            S_CMD: begin
                if (acked) r_d = go_bus(r_q, S_GO, 1'b1, OFS_CTRL, CTRL_RUN);
            end
            S_GO: begin
                if (acked) begin
                    r_d.chunk = '0;
                    if (r_q.cnt == '0)
                        r_d = go_bus(r_d, S_RELEASE, 1'b1, OFS_CTRL, CTRL_FREE);
                    else
                        r_d = go_bus(r_d, S_BUF_RD, 1'b0, OFS_STATUS, '0);
                end
            end
            S_BUF_RD: begin
                if (acked) begin
                    if (bus_rdata_i[BIT_BUFRDY]) begin
                        r_d.word = '0;
                        r_d      = park(r_d, S_DATA_GATE);
                    end else begin
                        r_d = park(r_q, S_BUF_WAIT);
                    end
                end
            end
            S_BUF_WAIT: begin
                if (tick) begin
                    if (r_q.gap == GAP_W'(BUF_GAP - 1))
                        r_d = go_bus(r_q, S_BUF_RD, 1'b0, OFS_STATUS, '0);
                    else
                        r_d.gap = r_q.gap + 1'b1;
                end
            end
            S_DATA_GATE: begin
                if (pair_empty) r_d = go_bus(r_q, S_DATA_RD, 1'b0, OFS_DATA, '0);
            end
            S_DATA_RD: begin
                if (acked) begin
                    load = 1'b1;
                    if (r_q.word == WORD_W'(WORDS_PER_CHUNK - 1)) begin
                        if (r_q.chunk == last_chunk) begin
                            r_d = park(r_q, S_DRAIN);
                        end else begin
                            r_d.chunk = r_q.chunk + 1'b1;
                            r_d       = go_bus(r_d, S_BUF_RD, 1'b0, OFS_STATUS, '0);
                        end
                    end else begin
                        r_d.word = r_q.word + 1'b1;
                        r_d      = park(r_d, S_DATA_GATE);
                    end
                end
            end
            S_DRAIN: begin
                if (pair_empty) r_d = go_bus(r_q, S_RELEASE, 1'b1, OFS_CTRL, CTRL_FREE);
            end
            S_RELEASE: begin
                if (acked) begin
                    r_d         = park(r_q, S_IDLE);
                    r_d.done    = 1'b1;
                    r_d.sectors = (r_q.err == ERR_NONE) ? r_q.cnt : '0;
                end
            end
            default: r_d = park(r_q, S_IDLE);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o      = (r_q.st != S_IDLE);
    assign done_o      = r_q.done;
    assign err_code_o  = r_q.err;
    assign sectors_o   = r_q.sectors;
    assign bus_req_o   = r_q.req;
    assign bus_we_o    = r_q.we;
    assign bus_addr_o  = r_q.addr;
    assign bus_wdata_o = r_q.wdata;
endmodule

// File: rtl/csr_checker.sv
module csr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy_o,
    input logic        done_o,
    input logic [1:0]  err_code_o,
    input logic [7:0]  sectors_o,
    input logic        bus_req_o,
    input logic        bus_we_o,
    input logic [6:0]  bus_addr_o,
    input logic [15:0] bus_wdata_o,
    input logic        bus_ack_i,
    input logic        byte_valid_o,
    input logic [7:0]  byte_data_o,
    input logic        byte_ready_i
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o)
            && $stable(bus_addr_o) && $stable(bus_wdata_o)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o); // R9

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_data_o)); // R6

    AST_READ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_we_o && bus_addr_o == 7'h40 |-> !byte_valid_o); // R7

    AST_RELEASE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(bus_req_o && bus_ack_i && bus_we_o
            && bus_addr_o == 7'h18 && bus_wdata_o == 16'h0000)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !byte_valid_o && !busy_o); // R8

    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && err_code_o != 2'd0 |-> sectors_o == 8'd0); // R8
endmodule

bind card_sector_reader csr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_code_o   (err_code_o),
    .sectors_o    (sectors_o),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_ack_i    (bus_ack_i),
    .byte_valid_o (byte_valid_o),
    .byte_data_o  (byte_data_o),
    .byte_ready_i (byte_ready_i)
);

// File: tb/sim_card_sector_reader.sv
`timescale 1ns/1ps
module sim_card_sector_reader;
    localparam int TICK_DIV = 2;
    localparam int LTRY = 4;
    localparam int LGAP = 3;
    localparam int RTRY = 5;
    localparam int RGAP = 2;
    localparam int BGAP = 2;
    localparam int WPC  = 16;
    localparam int CPS  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] lba_i = '0;
    logic [7:0]  count_i = '0;
    logic        busy_o, done_o;
    logic [1:0]  err_code_o;
    logic [7:0]  sectors_o;
    logic        bus_req_o, bus_we_o;
    logic [6:0]  bus_addr_o;
    logic [15:0] bus_wdata_o;
    logic        bus_ack_i = 1'b0;
    logic [15:0] bus_rdata_i = '0;
    logic        byte_valid_o;
    logic [7:0]  byte_data_o;
    logic        byte_ready_i = 1'b0;

    always #2 clk = ~clk;

    card_sector_reader #(
        .TICK_DIV(TICK_DIV), .LOCK_TRIES(LTRY), .LOCK_GAP(LGAP),
        .RDY_TRIES(RTRY), .RDY_GAP(RGAP), .BUF_GAP(BGAP),
        .WORDS_PER_CHUNK(WPC), .CHUNKS_PER_SECTOR(CPS)
    ) u0 (.*);

    int total = 0;
    int bad = 0;
    bit hung = 0;

    // controller model state
    bit   card_on, card_drop, granted, running;
    int   lock_after, rdy_after, lat, rmode;
    int   n_lock_rd, n_rdy_rd, n_buf_rd, n_data_rd, n_bytes, n_done, n_wr;
    int   cyc, wait_cnt, last_lock_ack, gap_bad, gate_bad, byte_bad;
    int   first_bad_act, first_bad_exp;
    logic [6:0]  wl_a [0:15];
    logic [15:0] wl_d [0:15];
    logic [23:0] lba_cur;

    function automatic logic [15:0] gen(int k);
        return 16'(k * 40503) ^ lba_cur[15:0] ^ 16'h5A00;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic serve();
        logic [15:0] st;
        logic [15:0] w;
        if (bus_we_o) begin
            if (n_wr < 16) begin
                wl_a[n_wr] = bus_addr_o;
                wl_d[n_wr] = bus_wdata_o;
            end
            n_wr++;
            if (bus_addr_o == 7'h18 && bus_wdata_o == 16'h0082) running = 1;
        end else if (bus_addr_o == 7'h04) begin
            st = '0;
            if (!granted) begin
                n_lock_rd++;
                if (n_lock_rd > 1 && cyc - last_lock_ack < (LGAP - 1) * TICK_DIV + 1)
                    gap_bad++;
                last_lock_ack = cyc;
                st[4] = card_on;
                if (n_lock_rd >= lock_after) granted = 1;
                st[1] = granted;
            end else if (!running) begin
                n_rdy_rd++;
                st[1] = 1;
                st[4] = card_on && !card_drop;
                st[8] = (n_rdy_rd >= rdy_after);
            end else begin
                n_buf_rd++;
                st[1] = 1;
                st[4] = 1;
                st[8] = 1;
                st[5] = (n_buf_rd % 3 == 2);
            end
            bus_rdata_i = st;
        end else if (bus_addr_o == 7'h40) begin
            if (byte_valid_o) gate_bad++;
            w = gen(n_data_rd);
            n_data_rd++;
            bus_rdata_i = w;
        end else begin
            bus_rdata_i = 16'hDEAD;
        end
    endtask

    // controller responder, downstream sink and done counter
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (done_o) n_done++;
            if (bus_ack_i) begin
                bus_ack_i = 1'b0;
            end else if (bus_req_o) begin
                wait_cnt++;
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    serve();
                    bus_ack_i = 1'b1;
                end
            end
            case (rmode)
                0: byte_ready_i = 1'b1;
                1: byte_ready_i = cyc[0];
                default: byte_ready_i = (cyc % 3 == 0);
            endcase
            if (byte_valid_o && byte_ready_i) begin
                logic [15:0] ew;
                logic [7:0] eb;
                ew = gen(n_bytes / 2);
                eb = n_bytes[0] ? ew[15:8] : ew[7:0];
                if (eb != byte_data_o) begin
                    if (byte_bad == 0) begin
                        first_bad_act = int'(byte_data_o);
                        first_bad_exp = int'(eb);
                    end
                    byte_bad++;
                end
                n_bytes++;
            end
        end
    end

    task automatic run(input string name, input logic [23:0] lba, input logic [7:0] cnt,
                       input bit card, input bit drop, input int la, input int ra,
                       input int l, input int rm, input bit extra, input int exp_err);
        int lim;
        logic [6:0]  ea [0:5];
        logic [15:0] ed [0:5];
        int ne;
        card_on = card; card_drop = drop; granted = 0; running = 0;
        lock_after = la; rdy_after = ra; lat = l; rmode = rm;
        n_lock_rd = 0; n_rdy_rd = 0; n_buf_rd = 0; n_data_rd = 0; n_bytes = 0;
        n_done = 0; n_wr = 0; wait_cnt = 0; gap_bad = 0; gate_bad = 0; byte_bad = 0;
        lba_cur = lba;
        @(negedge clk);
        start_i = 1'b1; lba_i = lba; count_i = cnt;
        @(negedge clk);
        start_i = 1'b0;
        if (extra) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1; lba_i = lba + 24'd7; count_i = cnt + 8'd2;
            @(negedge clk);
            start_i = 1'b0;
        end
        lim = 0;
        while (!done_o && lim < 60000) begin
            @(negedge clk);
            lim++;
        end
        if (lim >= 60000) begin
            hung = 1;
            chk(0, "R8", {name, " watchdog"}, lim, 0);
            return;
        end
        // R8: outcome reported with done
        chk(err_code_o == 2'(exp_err), "R8", {name, " err code"}, int'(err_code_o), exp_err);
        chk(sectors_o == (exp_err == 0 ? cnt : 8'd0), "R8", {name, " sectors"},
            int'(sectors_o), exp_err == 0 ? int'(cnt) : 0);
        // R5/R6: data volume and byte content
        chk(n_data_rd == (exp_err == 0 ? int'(cnt) * WPC * CPS : 0), "R5",
            {name, " data reads"}, n_data_rd, exp_err == 0 ? int'(cnt) * WPC * CPS : 0);
        chk(n_bytes == 2 * n_data_rd, "R8", {name, " bytes before done"}, n_bytes, 2 * n_data_rd);
        chk(byte_bad == 0, "R6", {name, " byte order"}, first_bad_act, first_bad_exp);
        chk(gate_bad == 0, "R7", {name, " read while byte pending"}, gate_bad, 0);
        chk(gap_bad == 0, "R1", {name, " lock poll spacing"}, gap_bad, 0);
        // R1/R4/R8: write sequence
        ea[0] = 7'h18; ed[0] = 16'h0002;
        if (exp_err == 0) begin
            ea[1] = 7'h10; ed[1] = lba[15:0];
            ea[2] = 7'h12; ed[2] = {8'h00, lba[23:16]};
            ea[3] = 7'h14; ed[3] = {8'h03, cnt};
            ea[4] = 7'h18; ed[4] = 16'h0082;
            ea[5] = 7'h18; ed[5] = 16'h0000;
            ne = 6;
        end else begin
            ea[1] = 7'h18; ed[1] = 16'h0000;
            ne = 2;
        end
        chk(n_wr == ne, "R4", {name, " write count"}, n_wr, ne);
        for (int i = 0; i < ne && i < n_wr; i++) begin
            chk(wl_a[i] == ea[i] && wl_d[i] == ed[i], i == 0 ? "R1" : "R4",
                {name, " write"}, int'({wl_a[i], wl_d[i]}), int'({ea[i], ed[i]}));
        end
        repeat (40) @(negedge clk);
        chk(n_done == 1 && !busy_o, "R10", {name, " single done"}, n_done, 1);
    endtask

    initial begin
        rmode = 0; lat = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !bus_req_o && !byte_valid_o && !done_o, "R9", "reset idle",
            int'({busy_o, bus_req_o, byte_valid_o, done_o}), 0);
        chk(sectors_o == 0 && err_code_o == 0, "R8", "reset outputs", int'(sectors_o), 0);

        run("ok1",        24'h12_3456, 8'd1, 1, 0, 1, 1, 1, 0, 0, 0);
        if (!hung) run("ok2slow",    24'hAB_CDEF, 8'd2, 1, 0, 2, 3, 3, 2, 0, 0);
        if (!hung) run("lock_last",  24'h00_0100, 8'd1, 1, 0, LTRY, RTRY, 2, 1, 0, 0);
        if (!hung) run("lock_fail",  24'h00_0200, 8'd1, 1, 0, 99, 1, 1, 0, 0, 2);
        chk(n_lock_rd == LTRY, "R1", "lock reads on timeout", n_lock_rd, LTRY);
        if (!hung) run("nocard",     24'h00_0300, 8'd1, 0, 0, 99, 1, 2, 0, 0, 1);
        chk(n_lock_rd == LTRY, "R1", "lock reads card absent", n_lock_rd, LTRY);
        if (!hung) run("card_gone",  24'h00_0400, 8'd1, 1, 1, 1, 1, 1, 0, 0, 1);
        chk(n_rdy_rd == 1, "R2", "ready reads before card loss", n_rdy_rd, 1);
        if (!hung) run("notready",   24'h00_0500, 8'd1, 1, 0, 1, 99, 1, 0, 0, 3);
        chk(n_rdy_rd == RTRY, "R3", "ready reads on timeout", n_rdy_rd, RTRY);
        if (!hung) run("zero",       24'hF0_0F00, 8'd0, 1, 0, 1, 2, 2, 0, 0, 0);
        chk(n_buf_rd == 0, "R11", "no buffer polls for zero count", n_buf_rd, 0);
        if (!hung) run("busy_start", 24'h55_AA55, 8'd1, 1, 0, 2, 2, 1, 1, 1, 0);
        if (!hung) run("ok3",        24'h7F_FFFF, 8'd3, 1, 0, 1, 1, 2, 0, 0, 0);
        chk(n_buf_rd >= 3 * CPS, "R5", "buffer polls per chunk", n_buf_rd, 3 * CPS);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL R8 global watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule